// File: doc/BRIEF.md
# Debug trigger state sequencer

This block is the sequencing stage of an on-chip debug trigger. It receives one-cycle match pulses from four comparator channels, numbered 0 to 3. It masks out the channels whose comparator is not enabled. It then walks through three intermediate states toward a Final state. Each intermediate state owns a 4-bit rule code. The code says, for each channel, whether a match there moves the sequencer to State1, State2, State3 or Final, or has no effect. When several enabled matches arrive in the same cycle, a match that leads to Final wins. Otherwise the lowest-numbered channel that has a real transition wins. A channel whose match has no effect never blocks another channel.

Software drives the `arm` level. Raising `arm` starts the sequencer in State1. Lowering it returns the sequencer to idle. Once Final is reached, `final_hit` stays high and the state holds until `arm` is lowered and raised again.

The three rule codes share a single register location. A 2-bit bank select picks which one is read or written. A code can be changed only while the sequencer is not armed. All pins are plain control and status signals, and there is no streaming interface.

Top module: `trig_seq`

## Requirements
- R1: After reset, `seq_state` is 0 (idle), `armed` is 0, `final_hit` is 0, and all three rule codes read back as 0.
- R2: A clock edge that samples `arm`=1 while `armed`=0 sets `armed`=1 and `seq_state`=1 (State1). State codes are: 0 idle, 1 State1, 2 State2, 3 State3, 4 Final.
- R3: A clock edge that samples `arm`=0 sets `armed`=0, `seq_state`=0 and `final_hit`=0, whatever the matches are.
- R4: In State1, State2 and State3, the rule code of that state decides each channel's target. The codes are:
  - 1 to 4: only channel (code-1) goes to Final.
  - 5: any channel goes to Final.
  - 6: channel 2 has no effect and the others go to Final.
  - 7: ch0 goes to State1 and ch1 goes to State3.
  - 8: ch0 goes to State1 and ch2 goes to State3.
  - 9: ch1 goes to State1 and ch3 goes to State3.
  - 10: ch1 goes to State2 and ch0 goes to Final.
  - 11: ch2 goes to State2 and ch0 goes to Final.
  - 12: ch3 goes to State2 and ch1 goes to Final.
  - 13: ch2 goes to State1 and ch3 goes to Final.
  - Any channel not listed for a code has no effect. The resulting transition is registered, with at most one per clock.
- R5: Codes 0, 14 and 15 are reserved: no match causes any transition.
- R6: If any enabled match in the cycle targets Final, the next state is Final.
- R7: If no enabled match targets Final, the lowest-numbered enabled match with a non-null target decides the next state. Null-target matches are skipped.
- R8: In Final, `final_hit` is 1 and the state holds while `arm` stays 1, whatever the matches are.
- R9: A match on channel c counts only when `comp_en[c]` is 1.
- R10: `cfg_bank` 0, 1 and 2 select the State1, State2 and State3 rule code in `cfg_rdata[3:0]`, and `cfg_rdata[7:4]` reads 0. Bank 3 reads 0 and ignores writes. A write stores `cfg_wdata[3:0]`.
- R11: While `armed`=1, writes leave every rule code unchanged.
- R12: While disarmed, matches are ignored and `seq_state` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | Arm level; high runs the sequencer |
| comp_en | input | 4 | Per-channel comparator enable |
| match | input | 4 | Per-channel match pulses |
| cfg_bank | input | 2 | Rule-code bank select |
| cfg_wr | input | 1 | Write strobe for the selected rule code |
| cfg_wdata | input | 8 | Write data; bits 3:0 used |
| cfg_rdata | output | 8 | Selected rule code, zero-extended |
| armed | output | 1 | Sequencer is armed |
| seq_state | output | 3 | Current state code |
| final_hit | output | 1 | Final state reached |

## Verification
The assertions assume the following about the inputs:
- `arm` is a level that software drives, and it is not toggled inside a single cycle.
- Match pulses are sampled only at clock edges.
- Rule codes are written only while the sequencer is disarmed.

The bench keeps to these assumptions:
- It changes every input on the falling edge.
- It pulses each match pattern for exactly one cycle.
- It always disarms before it reprograms the codes.

It reaches State2 and State3 through known preparatory codes before it applies the pattern under test.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int NUM_CH  = 4;
  localparam int NUM_ST  = 3;
  localparam int CODE_W  = 4;
  localparam int DATA_W  = 8;
  localparam int BANK_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FINAL = 3'd4
  } seq_state_e;

  // Target of a match on channel ch under a rule code; ST_IDLE means no effect.
  function automatic seq_state_e code_target(logic [CODE_W-1:0] code, int ch);
    case (code)
      4'd1, 4'd2, 4'd3, 4'd4: return (ch == int'(code) - 1) ? ST_FINAL : ST_IDLE;
      4'd5:  return ST_FINAL;
      4'd6:  return (ch == 2) ? ST_IDLE : ST_FINAL;
      4'd7:  return (ch == 0) ? ST_ONE : (ch == 1) ? ST_THREE : ST_IDLE;
      4'd8:  return (ch == 0) ? ST_ONE : (ch == 2) ? ST_THREE : ST_IDLE;
      4'd9:  return (ch == 1) ? ST_ONE : (ch == 3) ? ST_THREE : ST_IDLE;
      4'd10: return (ch == 1) ? ST_TWO : (ch == 0) ? ST_FINAL : ST_IDLE;
      4'd11: return (ch == 2) ? ST_TWO : (ch == 0) ? ST_FINAL : ST_IDLE;
      4'd12: return (ch == 3) ? ST_TWO : (ch == 1) ? ST_FINAL : ST_IDLE;
      4'd13: return (ch == 2) ? ST_ONE : (ch == 3) ? ST_FINAL : ST_IDLE;
      default: return ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/trig_seq_regs.sv
module trig_seq_regs
  import trig_seq_pkg::*;
#(
  parameter int N_ST  = NUM_ST,
  parameter int CW    = CODE_W,
  parameter int DW    = DATA_W,
  parameter int BW    = BANK_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   armed_i,
  input  logic                   wr_en_i,
  input  logic [BW-1:0]          bank_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic [N_ST-1:0][CW-1:0] codes_o
);
  logic [N_ST-1:0][CW-1:0] sc_q;

  for (genvar g = 0; g < N_ST; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sc_q[g] <= '0;
      end else if (wr_en_i && !armed_i && bank_i == BW'(g)) begin
        sc_q[g] <= wdata_i[CW-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < N_ST; g++) begin
      if (bank_i == BW'(g)) rdata_o[CW-1:0] = sc_q[g];
    end
  end

  assign codes_o = sc_q;

  assert_locked_while_armed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    armed_i |=> $stable(sc_q));
endmodule

// File: rtl/trig_seq_resolve.sv
module trig_seq_resolve
  import trig_seq_pkg::*;
#(
  parameter int N_CH = NUM_CH,
  parameter int N_ST = NUM_ST,
  parameter int CW   = CODE_W
) (
  input  seq_state_e              state_i,
  input  logic [N_ST-1:0][CW-1:0] codes_i,
  input  logic [N_CH-1:0]         match_i,
  output logic [CW-1:0]           cur_code_o,
  output logic                    hit_final_o,
  output logic                    go_o,
  output seq_state_e              next_o
);
  seq_state_e tgt [N_CH];

  always_comb begin
    case (state_i)
      ST_ONE:   cur_code_o = codes_i[0];
      ST_TWO:   cur_code_o = codes_i[1];
      ST_THREE: cur_code_o = codes_i[2];
      default:  cur_code_o = '0;
    endcase
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign tgt[c] = match_i[c] ? code_target(cur_code_o, c) : ST_IDLE;
  end

  always_comb begin
    hit_final_o = 1'b0;
    go_o        = 1'b0;
    next_o      = ST_IDLE;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (tgt[c] != ST_IDLE) begin
        go_o   = 1'b1;
        next_o = tgt[c];
      end
      if (tgt[c] == ST_FINAL) hit_final_o = 1'b1;
    end
    if (hit_final_o) next_o = ST_FINAL;
  end
endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
  import trig_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic       go_i,
  input  seq_state_e next_i,
  output seq_state_e state_o,
  output logic       armed_o
);
  seq_state_e state_q;
  logic       armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
    end else if (!arm_i) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      state_q <= ST_ONE;
      armed_q <= 1'b1;
    end else if (state_q != ST_FINAL && go_i) begin
      state_q <= next_i;
    end
  end

  assign state_o = state_q;
  assign armed_o = armed_q;

  assert_disarm_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> (state_q == ST_IDLE && !armed_q));
  assert_arm_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !armed_q) |=> (state_q == ST_ONE && armed_q));
  assert_final_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && state_q == ST_FINAL) |=> state_q == ST_FINAL);
  assert_disarmed_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> state_q == ST_IDLE);
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  logic [3:0]  comp_en,
  input  logic [3:0]  match,
  input  logic [1:0]  cfg_bank,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  output logic        armed,
  output logic [2:0]  seq_state,
  output logic        final_hit
);
  logic [NUM_ST-1:0][CODE_W-1:0] codes;
  logic [NUM_CH-1:0]             match_eff;
  logic [CODE_W-1:0]             cur_code;
  logic                          hit_final, go;
  seq_state_e                    nxt, state;

  trig_seq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .armed_i(armed), .wr_en_i(cfg_wr),
    .bank_i(cfg_bank), .wdata_i(cfg_wdata), .rdata_o(cfg_rdata), .codes_o(codes)
  );

  assign match_eff = match & comp_en & {NUM_CH{armed}};

  trig_seq_resolve u_res (
    .state_i(state), .codes_i(codes), .match_i(match_eff), .cur_code_o(cur_code),
    .hit_final_o(hit_final), .go_o(go), .next_o(nxt)
  );

  trig_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .go_i(go), .next_i(nxt),
    .state_o(state), .armed_o(armed)
  );

  assign seq_state = state;
  assign final_hit = (state == ST_FINAL);

  assert_final_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && armed && hit_final) |=> seq_state == 3'd4);
  assert_reserved_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && armed && (cur_code == 4'd0 || cur_code >= 4'd14)) |=> $stable(seq_state));
  assert_masked_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && armed && (match & comp_en) == 4'd0) |=> $stable(seq_state));
endmodule

// File: tb/trig_seq_tb.sv
module trig_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0;
  logic [3:0] comp_en = 4'hF;
  logic [3:0] match = 4'h0;
  logic [1:0] cfg_bank = 2'd0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       armed;
  logic [2:0] seq_state;
  logic       final_hit;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trig_seq u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .comp_en(comp_en), .match(match),
    .cfg_bank(cfg_bank), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .armed(armed), .seq_state(seq_state), .final_hit(final_hit)
  );

  // Reference rule table: 0 none, 1..3 State1..3, 4 Final.
  function automatic int ref_tgt(int code, int ch);
    if (code >= 1 && code <= 4) return (ch == code - 1) ? 4 : 0;
    if (code == 5) return 4;
    if (code == 6) return (ch == 2) ? 0 : 4;
    case (code)
      7:  begin if (ch == 0) return 1; if (ch == 1) return 3; end
      8:  begin if (ch == 0) return 1; if (ch == 2) return 3; end
      9:  begin if (ch == 1) return 1; if (ch == 3) return 3; end
      10: begin if (ch == 1) return 2; if (ch == 0) return 4; end
      11: begin if (ch == 2) return 2; if (ch == 0) return 4; end
      12: begin if (ch == 3) return 2; if (ch == 1) return 4; end
      13: begin if (ch == 2) return 1; if (ch == 3) return 4; end
      default: ;
    endcase
    return 0;
  endfunction

  function automatic int ref_next(int cur, int code, int m);
    int pick = 0;
    for (int ch = 0; ch < 4; ch++)
      if (m[ch] && ref_tgt(code, ch) == 4) return 4;
    for (int ch = 3; ch >= 0; ch--)
      if (m[ch] && ref_tgt(code, ch) != 0) pick = ref_tgt(code, ch);
    return (pick == 0) ? cur : pick;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int bank, int data);
    cfg_bank = 2'(bank); cfg_wdata = 8'(data); cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic rd(int bank, output int v);
    cfg_bank = 2'(bank);
    #1 v = int'(cfg_rdata);
  endtask

  task automatic pulse(int m);
    match = 4'(m);
    tick();
    match = 4'h0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int v;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 state", seq_state, 0);
    chk("R1 armed", armed, 0);
    chk("R1 final", final_hit, 0);
    for (int b = 0; b < 3; b++) begin rd(b, v); chk("R1 code", v, 0); end

    // R10 bank readback, upper bits zero, bank 3 inert
    wr(0, 8'hF3); wr(1, 8'hA7); wr(2, 8'h5C); wr(3, 8'hFF);
    rd(0, v); chk("R10 bank0", v, 3);
    rd(1, v); chk("R10 bank1", v, 7);
    rd(2, v); chk("R10 bank2", v, 12);
    rd(3, v); chk("R10 bank3", v, 0);

    // R12 matches ignored while disarmed
    match = 4'hF; tick(); tick(); match = 4'h0;
    chk("R12 state", seq_state, 0);
    chk("R12 armed", armed, 0);

    // R2 arm, then R11 writes blocked while armed
    arm = 1'b1; tick();
    chk("R2 armed", armed, 1);
    chk("R2 state", seq_state, 1);
    wr(0, 8'h09); wr(2, 8'h01);
    rd(0, v); chk("R11 bank0", v, 3);
    rd(2, v); chk("R11 bank2", v, 12);

    // R8 sticky final (State1 code 3 -> ch2 to Final)
    pulse(4'h4);
    chk("R8 state", seq_state, 4);
    chk("R8 flag", final_hit, 1);
    match = 4'hF; tick(); tick(); tick();
    chk("R8 hold", seq_state, 4);
    chk("R8 hold flag", final_hit, 1);
    // R3 disarm with matches active
    arm = 1'b0; tick(); match = 4'h0;
    chk("R3 state", seq_state, 0);
    chk("R3 armed", armed, 0);
    chk("R3 flag", final_hit, 0);

    // R9 enable masking sweep with code 5 in State1
    wr(0, 5);
    for (int en = 0; en < 16; en++) begin
      for (int m = 1; m < 16; m++) begin
        arm = 1'b0; tick();
        arm = 1'b1; tick();
        comp_en = 4'(en);
        pulse(m);
        chk("R9 mask", seq_state, ((m & en) != 0) ? 4 : 1);
      end
    end
    comp_en = 4'hF;

    // R4 R5 R6 R7 exhaustive sweep of state x code x pattern
    for (int s = 1; s <= 3; s++) begin
      for (int code = 0; code < 16; code++) begin
        arm = 1'b0; tick();
        wr(0, (s == 1) ? code : (s == 2) ? 10 : 7);
        wr(1, (s == 2) ? code : 0);
        wr(2, (s == 3) ? code : 0);
        for (int m = 0; m < 16; m++) begin
          arm = 1'b0; tick();
          arm = 1'b1; tick();
          if (s > 1) pulse(4'h2);
          if (seq_state != 3'(s)) chk("R4 prep", seq_state, s);
          pulse(m);
          if (code == 0 || code >= 14)
            chk("R5 reserved", seq_state, s);
          else if (ref_next(s, code, m) == 4)
            chk("R6 final first", seq_state, 4);
          else
            chk("R4 R7 decode", seq_state, ref_next(s, code, m));
          chk("R8 flag", final_hit, (ref_next(s, code, m) == 4 && code != 0 && code < 14) ? 1 : 0);
        end
      end
    end
    arm = 1'b0; tick();
    summary();
  end
endmodule